// File: doc/BRIEF.md
# Morphing Hart Issue Scheduler

This block sits at the front of a barrel-style pipeline that runs three hardware threads (harts). Each cycle it names the hart whose program counter, register file and control state feed the next fetch. The scheduler keeps one awake flag per hart. A software-interrupt wake request sets a hart's flag. A sleep request clears the flag of the hart that is issuing in that cycle.

The number of awake harts sets the execution mode. With three awake harts, pure interleaving keeps dependent pipeline stages apart, so no hazard logic is needed. With two, the harts alternate in a hybrid mode. With one, the core runs in order. In the last two modes there are too few harts between dependent stages, so the scheduler turns on the enables for the dependency checker, register bypass, branch predictor and flush logic. A build parameter can remove that behaviour entirely. Each time the mode changes, the block raises a one-cycle flush request, so that instructions issued under the old mode are discarded.

Top module: `morph_issue_sched`

## Requirements
- R1: After reset only hart 0 is awake: issue_hart is 0, issue_valid is 1, mode is 2'b01 and flush_req is 0.
- R2: With all three harts awake, mode is 2'b11, the issued hart advances 0→1→2→0 once per unstalled cycle, and all four hazard enables are 0.
- R3: With exactly one hart awake, mode is 2'b01, that hart is issued every cycle, and all four hazard enables equal MORPH_EN.
- R4: With exactly two harts awake, mode is 2'b10, issue alternates between the two awake harts, and all four hazard enables equal MORPH_EN. The search for the next hart starts at the hart after the current one and skips sleeping harts.
- R5: With no hart awake, mode is 2'b00, issue_valid is 0 and all hazard enables are 0.
- R6: A 1 on bit i of wake_req sets hart i awake from the next cycle on. A wake request for a hart that is already awake changes nothing.
- R7: sleep_req, while issue_valid is 1 and stall is 0, puts the issuing hart to sleep from the next cycle on. If a wake request for that same hart arrives in the same cycle, the wake wins.
- R8: While stall is 1, issue_hart holds its value, the rotation does not advance, and sleep_req has no effect.
- R9: flush_req is 1 in exactly the first cycle in which mode differs from its value in the previous cycle.
- R10: With MORPH_EN = 0, no hazard enable is ever asserted, whatever the number of awake harts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_req | input | 3 | Per-hart software-interrupt wake request |
| sleep_req | input | 1 | Put the currently issuing hart to sleep |
| stall | input | 1 | Freeze issue and rotation |
| issue_hart | output | 2 | Index of the hart issuing this cycle |
| issue_valid | output | 1 | The indexed hart is awake and issues |
| mode | output | 2 | 00 idle, 01 in-order, 10 hybrid, 11 full interleave |
| dep_chk_en | output | 1 | Enable for the data dependency checker |
| bypass_en | output | 1 | Enable for the register bypass network |
| bpred_en | output | 1 | Enable for the branch predictor |
| flush_en | output | 1 | Enable for the pipeline flush logic |
| flush_req | output | 1 | One-cycle pulse on a mode change |

## Verification
A wake request and a sleep request can land on the same clock edge. Either they name the same hart, or they name different harts, so that the awake count stays the same while the awake set changes. The bench drives both cases while a hart is issuing. It then checks that the same-hart case leaves the mode unchanged with no flush pulse, and that the other case changes which harts alternate without a mode change or a flush. A second instance built with MORPH_EN = 0 shares every input and must keep all hazard enables low through the same sequence.

// File: rtl/morph_sched_pkg.sv
package morph_sched_pkg;

  localparam int unsigned HARTS = 3;
  localparam int unsigned HW    = $clog2(HARTS);

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'b00,
    MODE_INORDER = 2'b01,
    MODE_HYBRID  = 2'b10,
    MODE_BARREL  = 2'b11
  } exec_mode_e;

  // number of awake harts; with three harts it equals the mode code
  function automatic logic [1:0] awake_count(input logic [HARTS-1:0] a);
    awake_count = 2'(a[0]) + 2'(a[1]) + 2'(a[2]);
  endfunction

  function automatic logic [HW-1:0] hart_after(input logic [HW-1:0] h);
    hart_after = (h == HW'(HARTS - 1)) ? '0 : h + HW'(1);
  endfunction

  // search from the hart after 'last', skip sleepers, fall back to 'last'
  function automatic logic [HW-1:0] pick_next(input logic [HW-1:0]    last,
                                              input logic [HARTS-1:0] a);
    logic [HW-1:0] c1;
    logic [HW-1:0] c2;
    c1 = hart_after(last);
    c2 = hart_after(c1);
    if (a[c1])      pick_next = c1;
    else if (a[c2]) pick_next = c2;
    else            pick_next = last;
  endfunction

endpackage

// File: rtl/hart_pool.sv
module hart_pool
  import morph_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HARTS-1:0] wake_req,
  input  logic             sleep_hit,
  input  logic [HW-1:0]    sleep_idx,
  output logic [HARTS-1:0] active_q
);

  logic [HARTS-1:0] sleep_mask;
  logic [HARTS-1:0] active_d;

  always_comb begin
    sleep_mask = sleep_hit ? (HARTS'(1) << sleep_idx) : '0;
    active_d   = (active_q & ~sleep_mask) | wake_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= HARTS'(1);
    else        active_q <= active_d;
  end

endmodule

// File: rtl/issue_rotor.sv
module issue_rotor
  import morph_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [HARTS-1:0] active,
  output logic [HW-1:0]    cur_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (advance) cur_q <= pick_next(cur_q, active);
  end

endmodule

// File: rtl/mode_unit.sv
module mode_unit
  import morph_sched_pkg::*;
#(
  parameter bit MORPH_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HARTS-1:0] active,
  output exec_mode_e       mode,
  output logic             hazard_en,
  output logic             mode_chg
);

  exec_mode_e prev_q;

  always_comb begin
    mode      = exec_mode_e'(awake_count(active));
    mode_chg  = (mode != prev_q);
    hazard_en = MORPH_EN && ((mode == MODE_INORDER) || (mode == MODE_HYBRID));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= MODE_INORDER;
    else        prev_q <= mode;
  end

endmodule

// File: rtl/morph_issue_sched.sv
module morph_issue_sched
  import morph_sched_pkg::*;
#(
  parameter bit MORPH_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] wake_req,
  input  logic       sleep_req,
  input  logic       stall,
  output logic [1:0] issue_hart,
  output logic       issue_valid,
  output logic [1:0] mode,
  output logic       dep_chk_en,
  output logic       bypass_en,
  output logic       bpred_en,
  output logic       flush_en,
  output logic       flush_req
);

  logic [HARTS-1:0] active_q;
  logic [HW-1:0]    cur_q;
  logic             sleep_hit;
  logic             hazard_en;
  logic             mode_chg;
  exec_mode_e       mode_w;

  assign issue_valid = active_q[cur_q];
  assign sleep_hit   = sleep_req && issue_valid && !stall;

  hart_pool u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .sleep_hit (sleep_hit),
    .sleep_idx (cur_q),
    .active_q  (active_q)
  );

  issue_rotor u_rotor (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (!stall),
    .active  (active_q),
    .cur_q   (cur_q)
  );

  mode_unit #(.MORPH_EN(MORPH_EN)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active_q),
    .mode      (mode_w),
    .hazard_en (hazard_en),
    .mode_chg  (mode_chg)
  );

  assign issue_hart = cur_q;
  assign mode       = mode_w;
  assign dep_chk_en = hazard_en;
  assign bypass_en  = hazard_en;
  assign bpred_en   = hazard_en;
  assign flush_en   = hazard_en;
  assign flush_req  = mode_chg;

endmodule

// File: rtl/morph_sched_chk.sv
module morph_sched_chk #(
  parameter bit MORPH_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] active,
  input logic [2:0] wake_req,
  input logic       sleep_hit,
  input logic       stall,
  input logic [1:0] issue_hart,
  input logic       issue_valid,
  input logic [1:0] mode,
  input logic       dep_chk_en,
  input logic       bypass_en,
  input logic       bpred_en,
  input logic       flush_en,
  input logic       flush_req
);

  logic primed;
  logic any_en;
  logic all_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign any_en = dep_chk_en || bypass_en || bpred_en || flush_en;
  assign all_en = dep_chk_en && bypass_en && bpred_en && flush_en;

  p_full_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (!stall && $countones(active) == 3) |=>
      issue_hart == (($past(issue_hart) == 2'd2) ? 2'd0 : $past(issue_hart) + 2'd1));

  p_full_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !any_en);

  p_narrow_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active) == 1 || $countones(active) == 2) |-> (all_en == MORPH_EN));

  p_single_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($countones(active) == 1 && issue_valid && !sleep_hit && wake_req == 3'b000)
      |=> $stable(issue_hart));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active == 3'b000) |-> (!issue_valid && mode == 2'b00 && !any_en));

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (wake_req != 3'b000) |=> ((active & $past(wake_req)) == $past(wake_req)));

  p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (sleep_hit && !wake_req[issue_hart]) |=> !active[$past(issue_hart)]);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    stall |=> $stable(issue_hart));

  p_flush_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    flush_req == (mode != $past(mode)));

  p_no_morph_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> MORPH_EN);

endmodule

bind morph_issue_sched morph_sched_chk #(.MORPH_EN(MORPH_EN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active      (active_q),
  .wake_req    (wake_req),
  .sleep_hit   (sleep_hit),
  .stall       (stall),
  .issue_hart  (issue_hart),
  .issue_valid (issue_valid),
  .mode        (mode),
  .dep_chk_en  (dep_chk_en),
  .bypass_en   (bypass_en),
  .bpred_en    (bpred_en),
  .flush_en    (flush_en),
  .flush_req   (flush_req)
);

// File: tb/morph_issue_sched_test.sv
`timescale 1ns/1ps
module morph_issue_sched_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] wake_req = 3'b000;
  logic       sleep_req = 1'b0;
  logic       stall = 1'b0;

  logic [1:0] hart_a, mode_a, hart_b, mode_b;
  logic       val_a, dep_a, byp_a, bp_a, fl_a, fr_a;
  logic       val_b, dep_b, byp_b, bp_b, fl_b, fr_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  morph_issue_sched uut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req), .stall(stall),
    .issue_hart(hart_a), .issue_valid(val_a), .mode(mode_a),
    .dep_chk_en(dep_a), .bypass_en(byp_a), .bpred_en(bp_a), .flush_en(fl_a), .flush_req(fr_a));

  morph_issue_sched #(.MORPH_EN(1'b0)) uut_nm (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req), .stall(stall),
    .issue_hart(hart_b), .issue_valid(val_b), .mode(mode_b),
    .dep_chk_en(dep_b), .bypass_en(byp_b), .bpred_en(bp_b), .flush_en(fl_b), .flush_req(fr_b));

  task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // inputs change at negedge; one rising edge; sample at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] h, input logic v,
                            input logic [1:0] m, input logic en, input logic fr);
    cmp(tag, "issue_hart", 4'(hart_a), 4'(h));
    cmp(tag, "issue_valid", 4'(val_a), 4'(v));
    cmp(tag, "mode", 4'(mode_a), 4'(m));
    cmp(tag, "hazard enables", {dep_a, byp_a, bp_a, fl_a}, {4{en}});
    cmp(tag, "flush_req", 4'(fr_a), 4'(fr));
    // R10: the instance without morphing keeps every enable low
    cmp("R10", "hazard enables (no morph)", {dep_b, byp_b, bp_b, fl_b}, 4'b0000);
    cmp(tag, "issue_hart (no morph)", 4'(hart_b), 4'(h));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 2'd0, 1'b1, 2'b01, 1'b1, 1'b0);
  endtask

  task automatic t_inorder();
    for (int i = 0; i < 3; i++) begin
      step();
      expect_out("R3", 2'd0, 1'b1, 2'b01, 1'b1, 1'b0);
    end
  endtask

  task automatic t_hybrid();
    wake_req = 3'b010;
    step();
    wake_req = 3'b000;
    expect_out("R6", 2'd0, 1'b1, 2'b10, 1'b1, 1'b1);
    step(); expect_out("R4", 2'd1, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd0, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd1, 1'b1, 2'b10, 1'b1, 1'b0);
    wake_req = 3'b010;          // already awake: no effect
    step();
    wake_req = 3'b000;
    expect_out("R6", 2'd0, 1'b1, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_full();
    logic [1:0] seq [4] = '{2'd2, 2'd0, 2'd1, 2'd2};
    wake_req = 3'b100;
    step();
    wake_req = 3'b000;
    expect_out("R9", 2'd1, 1'b1, 2'b11, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      expect_out("R2", seq[i], 1'b1, 2'b11, 1'b0, 1'b0);
    end
  endtask

  task automatic t_stall();
    stall = 1'b1;
    sleep_req = 1'b1;
    step(); expect_out("R8", 2'd2, 1'b1, 2'b11, 1'b0, 1'b0);
    step(); expect_out("R8", 2'd2, 1'b1, 2'b11, 1'b0, 1'b0);
    stall = 1'b0;
    sleep_req = 1'b0;
    step(); expect_out("R8", 2'd0, 1'b1, 2'b11, 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    sleep_req = 1'b1; wake_req = 3'b001;      // same hart: wake wins
    step();
    sleep_req = 1'b0; wake_req = 3'b000;
    expect_out("R7", 2'd1, 1'b1, 2'b11, 1'b0, 1'b0);
    sleep_req = 1'b1;                         // hart 1 sleeps
    step();
    sleep_req = 1'b0;
    expect_out("R7", 2'd2, 1'b1, 2'b10, 1'b1, 1'b1);
    step(); expect_out("R4", 2'd0, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd2, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd0, 1'b1, 2'b10, 1'b1, 1'b0);
    sleep_req = 1'b1; wake_req = 3'b010;      // hart 0 sleeps, hart 1 wakes
    step();
    sleep_req = 1'b0; wake_req = 3'b000;
    expect_out("R9", 2'd2, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd1, 1'b1, 2'b10, 1'b1, 1'b0);
    step(); expect_out("R4", 2'd2, 1'b1, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    sleep_req = 1'b1;
    step(); expect_out("R7", 2'd1, 1'b1, 2'b01, 1'b1, 1'b1);
    step(); expect_out("R5", 2'd1, 1'b0, 2'b00, 1'b0, 1'b1);
    step(); expect_out("R5", 2'd1, 1'b0, 2'b00, 1'b0, 1'b0);
    sleep_req = 1'b0;
    wake_req = 3'b100;
    step();
    wake_req = 3'b000;
    expect_out("R6", 2'd1, 1'b0, 2'b01, 1'b1, 1'b1);
    step(); expect_out("R3", 2'd2, 1'b1, 2'b01, 1'b1, 1'b0);
    step(); expect_out("R3", 2'd2, 1'b1, 2'b01, 1'b1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_inorder();
    t_hybrid();
    t_full();
    t_stall();
    t_collide();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule